// File: doc/BRIEF.md
# Third-Order Sinc Decimator for a One-Bit Modulator

This block turns the one-bit output stream of a second-order delta-sigma modulator into multi-bit samples at a lower rate. It produces the modulator's clock itself by dividing the system clock by a programmable amount. It samples the returned data bit at the moment that clock falls, because the modulator changes its bit just after the rising edge. Each captured bit becomes +1 (for a 1) or -1 (for a 0). The values then pass through three cascaded integrators that run at the modulator rate. Three comb (differentiator) stages run once for every `dec_ratio` samples. The result is a third-order sinc low-pass response, decimated by that ratio.

Each filter result is scaled to the programmed number of effective bits by keeping its most significant bits, counted from a full-scale position that follows from the decimation ratio. The result is then presented on `word_out` with a one-cycle `word_valid` strobe. The combs need consistent history before their outputs mean anything. For this reason the first three results after reset, or after any change of the effective ratio, are dropped.

Control is built from two small state machines. The clock generator has the states MC_LOW and MC_HIGH. It moves from one to the other on each half-period wrap of its cycle counter. The capture of a sample is the wrap taken out of MC_HIGH. The output gate has the states PRIME_A, PRIME_B, PRIME_C and STREAM. It steps forward on each comb result (PRIME_A to PRIME_B to PRIME_C to STREAM) and stays in STREAM. A ratio restart sends it from any state back to PRIME_A, and only results produced in STREAM are delivered.

Top module: `cic3_decimator`

## Requirements
- R1: After reset `mod_clk` is low. It then toggles after every `half_div`+1 system clocks, so its period is 2·(`half_div`+1) system clocks.
- R2: `mod_data` is sampled exactly once per modulator period, on the system clock edge at which `mod_clk` falls. A captured 1 enters the filter as +1 and a 0 as -1.
- R3: Each delivered result y equals the sum of h[k]·x[n−k], where n is the newest sample in its window and x is the ±1 sample sequence since reset (zero before reset). The weights h are the coefficients of (1 + z⁻¹ + … + z⁻⁽ᴿ⁻¹⁾)³. A steady all-ones input therefore gives +R³ and all-zeros gives −R³.
- R4: One result is produced for every R samples, counted from reset or from the last ratio restart. The effective ratio R is `dec_ratio`, with values 0 and 1 treated as 2 and values above 256 treated as 256.
- R5: After reset, and after any change of the effective ratio, the results at sample counts R, 2R and 3R (counted from that point) are suppressed. The first strobe comes for the result at sample count 4R.
- R6: The full-scale exponent is G = 3·ceil(log2 R). A result equal to +2^G is clamped to 2^G−1 before scaling.
- R7: With E = `eff_bits` (0 treated as 1), the delivered word is the clamped result arithmetically shifted right by G+1−E when E < G+1, and unshifted otherwise. It is sign-extended to the 25-bit `word_out`.
- R8: `word_valid` is high for exactly one system clock per delivered result, and `word_out` holds its value between strobes.
- R9: `word_valid` rises on the second system clock edge after the edge that captured the newest sample of its window.
- R10: While reset is asserted, `mod_clk`, `word_valid` and `word_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_data | input | 1 | One-bit data returned by the modulator |
| half_div | input | 8 | Half-period of `mod_clk` in system clocks, minus one |
| dec_ratio | input | 9 | Decimation ratio R (clamped to 2..256) |
| eff_bits | input | 5 | Effective output resolution in bits |
| mod_clk | output | 1 | Generated modulator clock |
| word_out | output | 25 | Filtered, scaled, sign-extended result |
| word_valid | output | 1 | One-cycle strobe marking a new `word_out` |

## Verification
The bench keeps the whole ±1 history and, at every sample, predicts from the convolution weights whether a strobe is due two clocks later and what word it carries. This prediction exposes a filter that integrates in the wrong order, samples on the rising edge, or drops the comb history on a restart. Directed cases cover a positive full-scale input, which an unclamped design would wrap to the most negative code. They also cover a negative full-scale input shifted to four bits, and out-of-range ratios at both ends, where a missing clamp gives a wrong scale or a wrong strobe rate. Ratio and resolution changes occur in the middle of a run. If the discard of three results is not re-armed, one or more unexpected strobes appear before the count of 4R samples.

// File: rtl/cic3_pkg.sv
package cic3_pkg;

    typedef enum logic {
        MC_LOW,
        MC_HIGH
    } mclk_state_e;

    typedef enum logic [1:0] {
        PRIME_A,
        PRIME_B,
        PRIME_C,
        STREAM
    } gate_state_e;

    // Smallest r with 2**r >= v (v >= 1).
    function automatic int ceil_log2(input logic [31:0] v);
        int r;
        r = 0;
        for (int i = 0; i < 31; i++) begin
            if ((32'd1 << i) < v) r = i + 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/cic3_mclk_gen.sv
module cic3_mclk_gen
    import cic3_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             bit_in,
    output logic             mclk,
    output logic             samp_stb,
    output logic             samp_bit
);

    mclk_state_e      state, state_n;
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = (cnt >= half_div);
    assign mclk = (state == MC_HIGH);

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            MC_LOW:  if (wrap) state_n = MC_HIGH;
            MC_HIGH: if (wrap) state_n = MC_LOW;
        endcase
    end

    // state register and half-period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MC_LOW;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= wrap ? '0 : cnt + 1'b1;
        end
    end

    // outputs: capture on the falling transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_stb <= 1'b0;
            samp_bit <= 1'b0;
        end else begin
            samp_stb <= (state == MC_HIGH) && wrap;
            if ((state == MC_HIGH) && wrap) samp_bit <= bit_in;
        end
    end

    // R1: the clock level only moves on a counter wrap
    a_r1_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $stable(state));

    // R2: a sample is taken exactly when the clock falls
    a_r2_fall_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mclk) |-> samp_stb);

    a_r2_capture_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |-> $fell(mclk));

endmodule

// File: rtl/cic3_integ.sv
module cic3_integ
    import cic3_pkg::*;
#(
    parameter int ACC_W   = 26,
    parameter int RATIO_W = 9,
    parameter int STAGES  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    samp_stb,
    input  logic                    samp_bit,
    input  logic [RATIO_W-1:0]      ratio,
    input  logic                    restart,
    output logic signed [ACC_W-1:0] acc_out,
    output logic                    comb_go
);

    localparam logic signed [ACC_W-1:0] PLUS_ONE  = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINUS_ONE = '1;

    logic signed [ACC_W-1:0] acc_q [STAGES];
    logic signed [ACC_W-1:0] acc_d [STAGES];
    logic signed [ACC_W-1:0] step;
    logic [RATIO_W-1:0]      cnt;
    logic                    last_of_block;

    assign step          = samp_bit ? PLUS_ONE : MINUS_ONE;
    assign last_of_block = (cnt >= ratio - 1'b1);
    assign acc_out       = acc_q[STAGES-1];

    // chained integrators, wrapping in two's complement
    always_comb begin
        acc_d[0] = acc_q[0] + step;
        for (int s = 1; s < STAGES; s++) acc_d[s] = acc_q[s] + acc_d[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) acc_q[s] <= '0;
        end else if (samp_stb) begin
            for (int s = 0; s < STAGES; s++) acc_q[s] <= acc_d[s];
        end
    end

    // decimation phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            comb_go <= 1'b0;
        end else begin
            comb_go <= 1'b0;
            if (restart) begin
                cnt <= '0;
            end else if (samp_stb) begin
                if (last_of_block) begin
                    cnt     <= '0;
                    comb_go <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4: phase stays below the ratio in force
    a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < ratio);

    // R9: a comb update follows a sample by one clock
    a_r9_go_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        comb_go |-> $past(samp_stb));

endmodule

// File: rtl/cic3_comb.sv
module cic3_comb
    import cic3_pkg::*;
#(
    parameter int ACC_W  = 26,
    parameter int STAGES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    comb_go,
    input  logic signed [ACC_W-1:0] acc_in,
    output logic signed [ACC_W-1:0] diff_out
);

    logic signed [ACC_W-1:0] tap  [STAGES+1];
    logic signed [ACC_W-1:0] dly_q[STAGES];

    // each stage subtracts its value from one decimated sample earlier
    always_comb begin
        tap[0] = acc_in;
        for (int s = 0; s < STAGES; s++) tap[s+1] = tap[s] - dly_q[s];
    end

    assign diff_out = tap[STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) dly_q[s] <= '0;
        end else if (comb_go) begin
            for (int s = 0; s < STAGES; s++) dly_q[s] <= tap[s];
        end
    end

    // R3: first comb delay holds the integrator value of the previous update
    a_r3_first_delay: assert property (@(posedge clk) disable iff (!rst_n)
        comb_go |=> (dly_q[0] == $past(acc_in)));

    a_r3_delay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !comb_go |=> $stable(dly_q[STAGES-1]));

endmodule

// File: rtl/cic3_out_gate.sv
module cic3_out_gate
    import cic3_pkg::*;
#(
    parameter int ACC_W   = 26,
    parameter int OUT_W   = 25,
    parameter int RATIO_W = 9,
    parameter int RES_W   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    comb_go,
    input  logic signed [ACC_W-1:0] diff_in,
    input  logic [RATIO_W-1:0]      ratio,
    input  logic [RES_W-1:0]        res_bits,
    output logic [OUT_W-1:0]        word,
    output logic                    valid
);

    localparam logic signed [ACC_W-1:0] ONE = ACC_W'(1);

    gate_state_e             state, state_n;
    int                      g_bits;
    int                      eb;
    int                      sh_amt;
    logic signed [ACC_W-1:0] full_pos;
    logic signed [ACC_W-1:0] y_sat;
    logic signed [ACC_W-1:0] y_shift;

    // scaling: clamp positive full scale, then keep the top E bits
    always_comb begin
        g_bits   = 3 * ceil_log2(32'(ratio));
        full_pos = ONE << g_bits;
        y_sat    = (diff_in == full_pos) ? full_pos - ONE : diff_in;
        eb       = (res_bits == '0) ? 1 : int'(32'(res_bits));
        sh_amt   = (eb < g_bits + 1) ? (g_bits + 1 - eb) : 0;
        y_shift  = y_sat >>> sh_amt;
    end

    // next-state logic of the priming gate
    always_comb begin
        state_n = state;
        unique case (state)
            PRIME_A: if (comb_go) state_n = PRIME_B;
            PRIME_B: if (comb_go) state_n = PRIME_C;
            PRIME_C: if (comb_go) state_n = STREAM;
            STREAM:  state_n = STREAM;
        endcase
        if (restart) state_n = PRIME_A;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PRIME_A;
        else        state <= state_n;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= comb_go && (state == STREAM) && !restart;
            if (comb_go && (state == STREAM) && !restart) word <= y_shift[OUT_W-1:0];
        end
    end

    // R5: nothing is delivered while priming
    a_r5_no_valid_priming: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($past(state) == STREAM));

    // R8: single-cycle strobe and held data
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(word));

    // R7: a delivered word fits the selected resolution
    a_r7_word_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((($signed(word) >>> ($past(eb) - 1)) == 0) ||
                   (($signed(word) >>> ($past(eb) - 1)) == -1)));

endmodule

// File: rtl/cic3_decimator.sv
module cic3_decimator
    import cic3_pkg::*;
#(
    parameter int MAX_RATIO = 256,
    parameter int DIV_W     = 8
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         mod_data,
    input  logic [DIV_W-1:0]                             half_div,
    input  logic [$clog2(MAX_RATIO+1)-1:0]               dec_ratio,
    input  logic [$clog2(3*$clog2(MAX_RATIO)+2)-1:0]     eff_bits,
    output logic                                         mod_clk,
    output logic [3*$clog2(MAX_RATIO):0]                 word_out,
    output logic                                         word_valid
);

    localparam int LOG_R   = $clog2(MAX_RATIO);
    localparam int RATIO_W = $clog2(MAX_RATIO + 1);
    localparam int ACC_W   = 2 + 3 * LOG_R;
    localparam int OUT_W   = 1 + 3 * LOG_R;
    localparam int RES_W   = $clog2(OUT_W + 1);
    localparam int STAGES  = 3;

    localparam logic [RATIO_W-1:0] R_LO = RATIO_W'(2);
    localparam logic [RATIO_W-1:0] R_HI = RATIO_W'(MAX_RATIO);

    logic [RATIO_W-1:0]      r_eff, ratio_q;
    logic                    restart;
    logic                    samp_stb, samp_bit, comb_go;
    logic signed [ACC_W-1:0] acc_top, comb_res;

    // ratio clamp and restart detection
    always_comb begin
        if (dec_ratio < R_LO)      r_eff = R_LO;
        else if (dec_ratio > R_HI) r_eff = R_HI;
        else                       r_eff = dec_ratio;
    end

    assign restart = (r_eff != ratio_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ratio_q <= R_LO;
        else        ratio_q <= r_eff;
    end

    cic3_mclk_gen #(
        .DIV_W (DIV_W)
    ) u_mclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_div (half_div),
        .bit_in   (mod_data),
        .mclk     (mod_clk),
        .samp_stb (samp_stb),
        .samp_bit (samp_bit)
    );

    cic3_integ #(
        .ACC_W   (ACC_W),
        .RATIO_W (RATIO_W),
        .STAGES  (STAGES)
    ) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_stb (samp_stb),
        .samp_bit (samp_bit),
        .ratio    (ratio_q),
        .restart  (restart),
        .acc_out  (acc_top),
        .comb_go  (comb_go)
    );

    cic3_comb #(
        .ACC_W  (ACC_W),
        .STAGES (STAGES)
    ) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .comb_go  (comb_go),
        .acc_in   (acc_top),
        .diff_out (comb_res)
    );

    cic3_out_gate #(
        .ACC_W   (ACC_W),
        .OUT_W   (OUT_W),
        .RATIO_W (RATIO_W),
        .RES_W   (RES_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .comb_go  (comb_go),
        .diff_in  (comb_res),
        .ratio    (ratio_q),
        .res_bits (eff_bits),
        .word     (word_out),
        .valid    (word_valid)
    );

    // R4: the ratio in force always lies in the legal range
    a_r4_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_q >= R_LO) && (ratio_q <= R_HI));

    // R10: quiet outputs right after reset release
    a_r10_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !word_valid);

endmodule

// File: tb/test_cic3_decimator.sv
module test_cic3_decimator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_data = 1'b0;
    logic [7:0]  half_div = '0;
    logic [8:0]  dec_ratio = 9'd4;
    logic [4:0]  eff_bits = 5'd25;
    logic        mod_clk;
    logic [24:0] word_out;
    logic        word_valid;

    cic3_decimator i_cic3_decimator (
        .clk        (clk),
        .rst_n      (rst_n),
        .mod_data   (mod_data),
        .half_div   (half_div),
        .dec_ratio  (dec_ratio),
        .eff_bits   (eff_bits),
        .mod_clk    (mod_clk),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    always #5 clk = ~clk;

    int     checks = 0;
    int     errors = 0;
    int     cyc = 0;
    int     h [0:800];
    int     hlen;
    int     hist [0:8191];
    int     idx, base, cur_r, cur_res, cur_div, dens;
    int     half_cnt, toggles, nvalid;
    logic   prev_mclk;
    logic   exp_v_d1, exp_v_d2;
    longint exp_w_d1, exp_w_d2;
    logic [24:0] last_word;
    logic   chg_req = 1'b0;
    int     chg_ratio, chg_res;
    logic   done = 1'b0;

    function automatic int eff_ratio(input int v);
        if (v < 2) return 2;
        if (v > 256) return 256;
        return v;
    endfunction

    function automatic int clog2i(input int v);
        int r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    function automatic logic pick_bit();
        return ($urandom_range(0, 99) < dens);
    endfunction

    task automatic build_h(input int r);
        int tmp [0:800];
        for (int i = 0; i <= 800; i++) h[i] = 0;
        h[0] = 1;
        hlen = 1;
        repeat (3) begin
            for (int i = 0; i < hlen + r - 1; i++) tmp[i] = 0;
            for (int i = 0; i < hlen; i++)
                for (int j = 0; j < r; j++) tmp[i+j] += h[i];
            hlen = hlen + r - 1;
            for (int i = 0; i < hlen; i++) h[i] = tmp[i];
        end
    endtask

    function automatic longint model_y(input int n);
        longint acc = 0;
        for (int k = 0; k < hlen; k++)
            if (n - k >= 1) acc += longint'(h[k]) * longint'(hist[n-k]);
        return acc;
    endfunction

    function automatic longint scale(input longint y, input int r, input int res);
        int g  = 3 * clog2i(r);
        int eb = (res == 0) ? 1 : res;
        int sh;
        if (y == (longint'(1) << g)) y = y - 1;
        sh = (eb < g + 1) ? (g + 1 - eb) : 0;
        return y >>> sh;
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // monitor, model and bit driver
    always @(negedge clk) begin
        if (!rst_n) begin
            idx = 0; base = 0; half_cnt = 0; toggles = 0;
            prev_mclk = 1'b0; exp_v_d1 = 1'b0; exp_v_d2 = 1'b0;
            exp_w_d1 = 0; exp_w_d2 = 0; last_word = '0;
        end else begin
            // R9 / R5: strobe exactly two edges after the qualifying capture
            if (word_valid !== exp_v_d2 || exp_v_d2)
                check("R9 strobe timing (R5 discard)", longint'(word_valid), longint'(exp_v_d2));
            if (word_valid && exp_v_d2)
                check("R3 R2 R7 filtered word", longint'($signed(word_out)), exp_w_d2);
            if (!word_valid)
                check("R8 word held", longint'(word_out), longint'(last_word));
            if (word_valid) begin
                last_word = word_out;
                nvalid++;
            end
            exp_v_d2 = exp_v_d1; exp_w_d2 = exp_w_d1; exp_v_d1 = 1'b0;

            half_cnt++;
            if (mod_clk !== prev_mclk) begin
                if (toggles > 0) check("R1 half period", half_cnt, cur_div + 1);
                toggles++;
                half_cnt = 0;
                if (!mod_clk) begin
                    idx++;
                    hist[idx] = mod_data ? 1 : -1;
                    if (((idx - base) % cur_r == 0) && ((idx - base) / cur_r >= 4)) begin
                        exp_v_d1 = 1'b1;
                        exp_w_d1 = scale(model_y(idx), cur_r, cur_res);
                    end
                end else begin
                    if (chg_req) begin
                        dec_ratio = 9'(chg_ratio);
                        eff_bits  = 5'(chg_res);
                        cur_res   = chg_res;
                        if (eff_ratio(chg_ratio) != cur_r) begin
                            cur_r = eff_ratio(chg_ratio);
                            base  = idx;
                            build_h(cur_r);
                        end
                        chg_req = 1'b0;
                    end
                    mod_data = pick_bit();
                end
            end
            prev_mclk = mod_clk;
        end
    end

    task automatic do_reset(input int d, input int r, input int res, input int dn);
        rst_n = 1'b0;
        half_div = 8'(d); dec_ratio = 9'(r); eff_bits = 5'(res);
        cur_div = d; cur_res = res; dens = dn;
        cur_r = eff_ratio(r);
        build_h(cur_r);
        mod_data = pick_bit();
        repeat (3) @(negedge clk);
        // R10: outputs quiet during reset
        check("R10 mod_clk in reset", longint'(mod_clk), 0);
        check("R10 valid in reset", longint'(word_valid), 0);
        check("R10 word in reset", longint'(word_out), 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_valids(input int n);
        int target = nvalid + n;
        while (nvalid < target) @(negedge clk);
    endtask

    task automatic request_change(input int r, input int res);
        chg_ratio = r; chg_res = res; chg_req = 1'b1;
        while (chg_req) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        nvalid = 0;

        // R6: positive full scale clamps (R=4, G=6): 64 -> 63, no shift at 25 bits
        do_reset(0, 4, 25, 100);
        wait_valids(3);
        check("R6 clamp at full scale", longint'($signed(word_out)), 63);

        // R7: negative full scale R=8 -> -512, four bits -> -8
        do_reset(1, 8, 4, 0);
        wait_valids(3);
        check("R7 truncation to four bits", longint'($signed(word_out)), -8);

        // R4: ratio above the maximum behaves as 256; R6 clamp then 8 bits -> 127
        do_reset(0, 300, 8, 100);
        wait_valids(2);
        check("R4 upper ratio clamp", longint'($signed(word_out)), 127);

        // R4: ratio 1 behaves as 2, half-density input
        do_reset(2, 1, 25, 50);
        wait_valids(4);

        // random segments with mid-run ratio and resolution changes (R5)
        for (int seg = 0; seg < 6; seg++) begin
            do_reset($urandom_range(1, 3), $urandom_range(0, 20),
                     $urandom_range(0, 25), $urandom_range(0, 100));
            wait_valids(3);
            for (int c = 0; c < 2; c++) begin
                request_change($urandom_range(0, 20), $urandom_range(0, 25));
                wait_valids(3);
            end
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule